// File: doc/BRIEF.md
# Processor Status Word Update Unit

This block holds a processor's 16-bit status word and applies to it the zero-group operations that change it directly. These are: raising or lowering the interrupt priority, setting or clearing condition flags under a mask, producing the flags for a byte swap, and a full reload of the word when an interrupt return pops it from the stack. Each operation arrives as one item on a valid/ready input stream. The item carries an operation select, the instruction word and a 16-bit operand. The unit applies the operation on the clock edge that accepts the item. It then presents one result item on a valid/ready output stream. For a byte swap the result is the swapped operand. For every other operation it is the new status word.

The privilege mode is taken from bits 15:14 of the held status word, where 00 means kernel. A priority change issued outside kernel mode is dropped silently: nothing traps and the word stays as it was. The flag result of a byte swap is unusual. N follows bit 15 of the swapped value, but Z looks only at its low byte.

Back-pressure rules: an input item is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output item is held unchanged and no new input is taken.

Top module: `psw_update_unit`

## Requirements
- R1: Synchronous reset clears the status word to 0 and empties the output (`out_valid` = 0).
- R2: Set-priority (`in_op` = 0) accepted while status bits 15:14 are 00 replaces status bits 7:5 with instruction bits 2:0. All other bits keep their values.
- R3: Set-priority accepted while status bits 15:14 are not 00 leaves the whole status word unchanged.
- R4: Flag set/clear (`in_op` = 1) writes instruction bit 4 into each of N, Z, V and C (status bits 3, 2, 1, 0) whose enable is set. The enables are instruction bits 3, 2, 1, 0 respectively. Other flags and all other bits keep their values.
- R5: Byte swap (`in_op` = 2) yields on `out_data` the operand with its high and low bytes exchanged.
- R6: After byte swap, N equals bit 15 of the swapped value, Z is 1 only if the swapped value's low byte is zero, and V and C are 0. Bits 15:4 keep their values.
- R7: Load (`in_op` = 3) writes the operand into the whole status word.
- R8: For operations 0, 1 and 3, the result item on `out_data` equals the status word produced by that operation.
- R9: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. The status word changes only when an item is accepted. A stalled output item stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation item present |
| in_ready | output | 1 | Unit can accept an operation item |
| in_op | input | 2 | Operation: 0 priority, 1 flags, 2 byte swap, 3 load |
| in_inst | input | 16 | Instruction word of the operation |
| in_operand | input | 16 | Byte-swap operand or status word to load |
| out_valid | output | 1 | Result item present |
| out_ready | input | 1 | Consumer takes the result item |
| out_data | output | 16 | Swapped operand, or the new status word |
| psw | output | 16 | Current status word |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, the priority field at bits 7:5 and the mode field at bits 15:14. With these values the test reaches every combination of the flag set/clear instruction bits. It reaches priority changes in kernel mode and in two non-kernel modes. It also covers byte swaps whose low result byte is zero while bit 15 is set, and the reverse. A consumer that drops `out_ready` at pseudo-random times produces stalls. Under those stalls the bench checks that no item is lost or duplicated and that the status word moves only on accepted items.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    OP_SPL  = 2'd0,
    OP_CC   = 2'd1,
    OP_SWAB = 2'd2,
    OP_LOAD = 2'd3
  } psw_op_e;

  // flag positions inside the status word
  localparam int FLAG_CNT = 4;
  localparam int BIT_C    = 0;
  localparam int BIT_V    = 1;
  localparam int BIT_Z    = 2;
  localparam int BIT_N    = 3;
endpackage

// File: rtl/psw_cc_unit.sv
module psw_cc_unit
  import psw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]      psw_in,
  input  logic [FLAG_CNT:0] ctl,      // [FLAG_CNT] = set/clear, [FLAG_CNT-1:0] = enables
  output logic [W-1:0]      psw_out
);
  localparam int SEL = FLAG_CNT;

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    assign psw_out[i] = ctl[i] ? ctl[SEL] : psw_in[i];
  end
  assign psw_out[W-1:FLAG_CNT] = psw_in[W-1:FLAG_CNT];
endmodule

// File: rtl/psw_spl_unit.sv
module psw_spl_unit #(
  parameter int W        = 16,
  parameter int PRI_LSB  = 5,
  parameter int PRI_W    = 3,
  parameter int MODE_LSB = 14,
  parameter int MODE_W   = 2
) (
  input  logic [W-1:0]     psw_in,
  input  logic [PRI_W-1:0] new_pri,
  output logic             is_kernel,
  output logic [W-1:0]     psw_out
);
  localparam int PRI_MSB  = PRI_LSB + PRI_W - 1;
  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

  assign is_kernel = (psw_in[MODE_MSB:MODE_LSB] == '0);

  always_comb begin
    psw_out = psw_in;
    if (is_kernel) psw_out[PRI_MSB:PRI_LSB] = new_pri;
  end
endmodule

// File: rtl/psw_swab_unit.sv
module psw_swab_unit
  import psw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] psw_in,
  input  logic [W-1:0] operand,
  output logic [W-1:0] swapped,
  output logic [W-1:0] psw_out
);
  localparam int HALF = W / 2;

  assign swapped = {operand[HALF-1:0], operand[W-1:HALF]};

  always_comb begin
    psw_out        = psw_in;
    psw_out[BIT_N] = swapped[W-1];
    psw_out[BIT_Z] = (swapped[HALF-1:0] == '0);
    psw_out[BIT_V] = 1'b0;
    psw_out[BIT_C] = 1'b0;
  end
endmodule

// File: rtl/psw_update_unit.sv
module psw_update_unit
  import psw_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRI_LSB  = 5,
  parameter int PRI_W    = 3,
  parameter int MODE_LSB = 14,
  parameter int MODE_W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_inst,
  input  logic [W-1:0] in_operand,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic [W-1:0] psw
);
  logic [W-1:0] psw_q, out_data_q;
  logic         out_valid_q;
  logic [W-1:0] psw_cc, psw_spl, psw_swab, swapped, psw_nxt, data_nxt;
  logic         kernel;
  logic         accept;
  psw_op_e      op;

  assign op       = psw_op_e'(in_op);
  assign in_ready = !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  psw_cc_unit #(.W(W)) u_cc (
    .psw_in (psw_q),
    .ctl    (in_inst[FLAG_CNT:0]),
    .psw_out(psw_cc)
  );

  psw_spl_unit #(
    .W(W), .PRI_LSB(PRI_LSB), .PRI_W(PRI_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W)
  ) u_spl (
    .psw_in   (psw_q),
    .new_pri  (in_inst[PRI_W-1:0]),
    .is_kernel(kernel),
    .psw_out  (psw_spl)
  );

  psw_swab_unit #(.W(W)) u_swab (
    .psw_in (psw_q),
    .operand(in_operand),
    .swapped(swapped),
    .psw_out(psw_swab)
  );

  always_comb begin
    unique case (op)
      OP_SPL:  psw_nxt = psw_spl;
      OP_CC:   psw_nxt = psw_cc;
      OP_SWAB: psw_nxt = psw_swab;
      default: psw_nxt = in_operand;
    endcase
    data_nxt = (op == OP_SWAB) ? swapped : psw_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psw_q       <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (accept) begin
        psw_q       <= psw_nxt;
        out_data_q  <= data_nxt;
        out_valid_q <= 1'b1;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign psw       = psw_q;

  // status word moves only on accepted items
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(accept) && !$past(rst)) |-> $stable(psw_q));

  // stalled output item is held
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // priority change outside kernel mode is dropped
  p_spl_user_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SPL && !kernel) |=> $stable(psw_q));

  // byte swap always clears V and C
  p_swab_vc_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SWAB) |=> (psw_q[BIT_V] == 1'b0 && psw_q[BIT_C] == 1'b0));

  // flag set with C enabled leaves C high
  p_cc_set_c_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_CC && in_inst[FLAG_CNT] && in_inst[BIT_C]) |=> psw_q[BIT_C]);

  // load writes the whole word
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_LOAD) |=> (psw_q == $past(in_operand)));
endmodule

// File: tb/psw_update_unit_bench.sv
module psw_update_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = '0;
  logic [W-1:0] in_inst = '0;
  logic [W-1:0] in_operand = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic [W-1:0] psw;

  int checks = 0;
  int failures = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] model_psw = '0;

  typedef struct { logic [W-1:0] data; string req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  psw_update_unit u_psw_update_unit (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_inst(in_inst), .in_operand(in_operand),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .psw(psw)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // consumer: random back-pressure when enabled
  always @(negedge clk) out_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;

  // monitor: compare results taken at the coming edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!rst) begin
        if (out_valid && !out_ready) check("R9 ready-low", {15'd0, in_ready}, 16'd0);
        if (out_valid && out_ready) begin
          if (sb.size() == 0) check("R9 extra item", out_data, 16'hxxxx);
          else begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, out_data, e.data);
          end
        end
      end
    end
  end

  // driver: model from the requirements, push expected, drive item
  task automatic do_op(logic [1:0] op, logic [W-1:0] inst, logic [W-1:0] opnd, string req);
    logic [W-1:0] nxt, dat;
    bit taken;
    nxt = model_psw;
    dat = '0;
    case (op)
      2'd0: if (model_psw[15:14] == 2'b00) nxt[7:5] = inst[2:0];        // R2 / R3
      2'd1: for (int i = 0; i < 4; i++) if (inst[i]) nxt[i] = inst[4];   // R4
      2'd2: begin                                                        // R5 / R6
        dat = {opnd[7:0], opnd[15:8]};
        nxt[3] = dat[15];
        nxt[2] = (dat[7:0] == 8'h00);
        nxt[1] = 1'b0;
        nxt[0] = 1'b0;
      end
      default: nxt = opnd;                                               // R7
    endcase
    if (op != 2'd2) dat = nxt;                                           // R8
    sb.push_back('{data: dat, req: (op == 2'd2) ? "R5" : "R8"});
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_inst = inst; in_operand = opnd;
    forever begin
      #3;
      taken = in_ready;
      @(posedge clk);
      if (taken) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    model_psw = nxt;
    check(req, psw, model_psw);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 psw", psw, 16'h0000);
    check("R1 out_valid", {15'd0, out_valid}, 16'd0);

    // idle cycles: no change (R9)
    repeat (4) @(negedge clk);
    check("R9 idle", psw, 16'h0000);

    // load (R7)
    do_op(2'd3, 16'h0000, 16'h1a5a, "R7");
    do_op(2'd3, 16'h0000, 16'h0000, "R7");

    // every flag set/clear combination from two starting words (R4)
    for (int s = 0; s < 2; s++) begin
      do_op(2'd3, 16'h0000, s ? 16'h00ff : 16'h0100, "R7");
      for (int k = 0; k < 32; k++) do_op(2'd1, 16'o000240 | W'(k), 16'h0000, "R4");
    end

    // priority in kernel mode (R2)
    do_op(2'd3, 16'h0000, 16'h001f, "R7");
    for (int p = 0; p < 8; p++) do_op(2'd0, 16'o000230 | W'(p), 16'h0000, "R2");

    // priority in non-kernel modes (R3)
    do_op(2'd3, 16'h0000, 16'hc0a0, "R7");
    for (int p = 0; p < 8; p++) do_op(2'd0, 16'o000230 | W'(p), 16'h0000, "R3");
    do_op(2'd3, 16'h0000, 16'h4040, "R7");
    do_op(2'd0, 16'o000237, 16'h0000, "R3");

    // byte swap corner values (R6)
    do_op(2'd3, 16'h0000, 16'h0003, "R7");
    do_op(2'd2, 16'o000300, 16'h00ff, "R6");  // -> ff00, N=1 Z=1
    do_op(2'd2, 16'o000300, 16'hff00, "R6");  // -> 00ff, N=0 Z=0
    do_op(2'd2, 16'o000300, 16'h0000, "R6");  // -> 0000, Z=1
    do_op(2'd2, 16'o000300, 16'h8001, "R6");  // -> 0180, Z=0 N=0

    // random work under back-pressure (R9)
    stall_en = 1'b1;
    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      do_op(op, W'($urandom), W'($urandom), "R9");
    end
    stall_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 drained", W'(sb.size()), 16'd0);
    check("R9 idle-final", psw, model_psw);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule